// File: doc/BRIEF.md
# Dual-Bit Transmit SPI Master

This block is an SPI master that moves one 8-bit word per command, most significant bit first. Each command chooses one of two modes. In standard mode, one bit goes out on the data-out line per serial clock. In dual mode, two bits go out per serial clock: the upper bit of each pair goes on the data-out line and the lower bit goes on a spare chip-select pin. Dual mode is for transmit only. A read is done as a standard-mode transfer, and that transfer still has to carry a transmit byte. The byte captured from MISO during a standard transfer is presented on a receive output when the transfer completes.

There are three device indices and two select lines. Indices 0 and 1 share one select line. Index 2 has a line of its own. A select stays asserted after its transfer ends. The host must issue an explicit deselect, which raises both lines, after every command. A divider value is sampled when the transfer starts and sets the length of each serial clock phase. For every bit slot, the data and spare pin are set up while the serial clock is low. The clock is then raised with the data held.

Top module: `dual_spi_tx_master`

## Requirements
- R1: After reset, sclk_o=0, mosi_o=0, cs_shared_no=1, cs_dev2_no=1, cs_aux_o=1, busy_o=0, done_o=0 and rx_byte_o=0.
- R2: A standard transfer (dual_i=0) sends 8 slots, bit 7 first, one bit per slot on mosi_o. Each slot is a low phase of div+1 cycles in which the data is set up, followed by a high phase of div+1 cycles with the data unchanged. busy_o is 1 throughout.
- R3: A dual transfer (dual_i=1) sends 4 slots with the same phase timing. Slot k puts tx bit 7-2k on mosi_o and tx bit 6-2k on cs_aux_o.
- R4: During a standard transfer and while idle, cs_aux_o stays at 1.
- R5: An accepted start with dev_i=2 drives cs_dev2_no=0 and cs_shared_no=1. Any other dev_i value (0, 1 or 3) drives cs_shared_no=0 and cs_dev2_no=1. The selection is held after the transfer ends, until a deselect or the next start.
- R6: desel_i while idle, with no start in the same cycle, drives cs_shared_no=1 and cs_dev2_no=1. While busy it has no effect.
- R7: MISO is captured at each rising sclk_o, MSB first. rx_byte_o takes the captured byte in the cycle done_o is 1 after a standard transfer. A dual transfer leaves rx_byte_o unchanged.
- R8: done_o is a single-cycle pulse in the cycle after the last high phase ends, with sclk_o=0 and busy_o=0. A transfer therefore lasts 2*(div+1)*slots cycles.
- R9: start_i while busy is ignored: the byte, mode, device and divider of the running transfer are kept.
- R10: div_i is sampled only when a start is accepted. Changes to it during a transfer do not alter the phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted while idle |
| tx_byte_i | input | WORD_W | Byte to transmit |
| dual_i | input | 1 | 1 selects two bits per clock |
| dev_i | input | 2 | Device index |
| desel_i | input | 1 | Deselect command |
| div_i | input | DIV_W | Phase length minus one, in system clocks |
| miso_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out (upper bit in dual mode) |
| cs_shared_no | output | 1 | Select for devices 0 and 1, active low |
| cs_dev2_no | output | 1 | Select for device 2, active low |
| cs_aux_o | output | 1 | Spare select pin, carries the lower bit in dual mode |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| rx_byte_o | output | WORD_W | Byte captured in the last standard transfer |

## Verification
The assertions check, on every cycle, the following rules. Data and the spare pin hold still while sclk_o is high. At most one select line is low at any time. The selects are frozen during a transfer. done_o is a lone pulse that follows a high phase. rx_byte_o changes only together with done_o. An idle start always makes the block busy. The bench scenarios are needed for the rest: bit ordering in each mode, the exact phase counts for several divider values, the device-to-line mapping, MISO capture, dual mode leaving the receive byte unchanged, and the proof that a mid-transfer start, deselect or divider change is ignored.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  localparam int unsigned WORD_W_DEF = 8;
  localparam int unsigned DIV_W_DEF  = 8;
  localparam logic [1:0]  DEV_OWN_LINE = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH
  } phase_e;
endpackage

// File: rtl/dspi_phase_timer.sv
module dspi_phase_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_i) div_q <= div_i;
      if (!run_i || cnt_q == div_q) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == div_q);
endmodule

// File: rtl/dspi_ctrl.sv
module dspi_ctrl
  import dspi_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dual_i,
  input  logic tick_i,
  output logic busy_o,
  output logic sclk_o,
  output logic done_o,
  output logic dual_o,
  output logic load_o,
  output logic sample_o,
  output logic advance_o,
  output logic finish_o
);
  localparam int unsigned SLOT_W = $clog2(WORD_W);
  localparam logic [SLOT_W-1:0] LAST_STD  = SLOT_W'(WORD_W - 1);
  localparam logic [SLOT_W-1:0] LAST_DUAL = SLOT_W'(WORD_W / 2 - 1);

  phase_e            st_q;
  logic [SLOT_W-1:0] slot_q;
  logic              dual_q;
  logic              done_q;
  logic              last_slot;

  assign last_slot = slot_q == (dual_q ? LAST_DUAL : LAST_STD);
  assign load_o    = (st_q == ST_IDLE) && start_i;
  assign sample_o  = (st_q == ST_LOW) && tick_i;
  assign finish_o  = (st_q == ST_HIGH) && tick_i && last_slot;
  assign advance_o = (st_q == ST_HIGH) && tick_i && !last_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      dual_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish_o;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_LOW;
          slot_q <= '0;
          dual_q <= dual_i;
        end
        ST_LOW:  if (tick_i) st_q <= ST_HIGH;
        ST_HIGH: if (tick_i) begin
          if (last_slot) st_q <= ST_IDLE;
          else begin
            st_q   <= ST_LOW;
            slot_q <= slot_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = st_q != ST_IDLE;
  assign sclk_o = st_q == ST_HIGH;
  assign done_o = done_q;
  assign dual_o = dual_q;
endmodule

// File: rtl/dspi_shifter.sv
module dspi_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic              dual_i,
  input  logic              busy_i,
  input  logic              advance_i,
  input  logic              sample_i,
  input  logic              finish_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic              aux_o,
  output logic [WORD_W-1:0] rx_o
);
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_sh_q;
  logic [WORD_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
    end else begin
      if (load_i)         tx_q <= tx_i;
      else if (advance_i) tx_q <= dual_i ? {tx_q[WORD_W-3:0], 2'b00}
                                         : {tx_q[WORD_W-2:0], 1'b0};
      if (sample_i)             rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
      if (finish_i && !dual_i)  rx_q    <= rx_sh_q;
    end
  end

  // spare pin idles high; it carries data only in dual mode
  assign mosi_o = tx_q[WORD_W-1];
  assign aux_o  = (busy_i && dual_i) ? tx_q[WORD_W-2] : 1'b1;
  assign rx_o   = rx_q;
endmodule

// File: rtl/dspi_csel.sv
module dspi_csel
  import dspi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] dev_i,
  input  logic       desel_i,
  output logic       cs_shared_no,
  output logic       cs_dev2_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_shared_no <= 1'b1;
      cs_dev2_no   <= 1'b1;
    end else if (load_i) begin
      cs_shared_no <= (dev_i == DEV_OWN_LINE);
      cs_dev2_no   <= (dev_i != DEV_OWN_LINE);
    end else if (desel_i) begin
      cs_shared_no <= 1'b1;
      cs_dev2_no   <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_spi_tx_master.sv
module dual_spi_tx_master
  import dspi_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned DIV_W  = DIV_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_byte_i,
  input  logic              dual_i,
  input  logic [1:0]        dev_i,
  input  logic              desel_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_shared_no,
  output logic              cs_dev2_no,
  output logic              cs_aux_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_byte_o
);
  logic busy, dual_q, load, sample, advance, finish, tick, desel_ok;

  assign desel_ok = desel_i && !busy && !start_i;

  dspi_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .div_i  (div_i),
    .run_i  (busy),
    .tick_o (tick)
  );

  dspi_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .dual_i    (dual_i),
    .tick_i    (tick),
    .busy_o    (busy),
    .sclk_o    (sclk_o),
    .done_o    (done_o),
    .dual_o    (dual_q),
    .load_o    (load),
    .sample_o  (sample),
    .advance_o (advance),
    .finish_o  (finish)
  );

  dspi_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .tx_i      (tx_byte_i),
    .dual_i    (dual_q),
    .busy_i    (busy),
    .advance_i (advance),
    .sample_i  (sample),
    .finish_i  (finish),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .aux_o     (cs_aux_o),
    .rx_o      (rx_byte_o)
  );

  dspi_csel u_csel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .dev_i        (dev_i),
    .desel_i      (desel_ok),
    .cs_shared_no (cs_shared_no),
    .cs_dev2_no   (cs_dev2_no)
  );

  assign busy_o = busy;
endmodule

// File: rtl/dspi_checker.sv
module dspi_checker #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              sclk_o,
  input logic              mosi_o,
  input logic              cs_aux_o,
  input logic              cs_shared_no,
  input logic              cs_dev2_no,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] rx_byte_o
);
  a_r2_data_held_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable({mosi_o, cs_aux_o}));

  a_r5_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~cs_shared_no, ~cs_dev2_no}) <= 1);

  a_r6_cs_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable({cs_shared_no, cs_dev2_no}));

  a_r7_rx_only_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rx_byte_o));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!sclk_o && $past(sclk_o) && !busy_o));

  a_r9_start_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind dual_spi_tx_master dspi_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .sclk_o       (sclk_o),
  .mosi_o       (mosi_o),
  .cs_aux_o     (cs_aux_o),
  .cs_shared_no (cs_shared_no),
  .cs_dev2_no   (cs_dev2_no),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .rx_byte_o    (rx_byte_o)
);

// File: tb/tb_dual_spi_tx_master.sv
module tb_dual_spi_tx_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       dual = 1'b0;
  logic [1:0] dev = '0;
  logic       desel = 1'b0;
  logic [7:0] div = '0;
  logic       miso = 1'b0;
  logic       sclk, mosi, cs_sh_n, cs_d2_n, aux, busy, done;
  logic [7:0] rx;

  int total = 0;
  int bad   = 0;
  logic [7:0] rx_model = '0;

  always #10 clk = ~clk;

  dual_spi_tx_master dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_byte_i(tx_byte),
    .dual_i(dual), .dev_i(dev), .desel_i(desel), .div_i(div), .miso_i(miso),
    .sclk_o(sclk), .mosi_o(mosi), .cs_shared_no(cs_sh_n), .cs_dev2_no(cs_d2_n),
    .cs_aux_o(aux), .busy_o(busy), .done_o(done), .rx_byte_o(rx)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Runs one transfer and checks every cycle of it. poke: mid-transfer
  // start/deselect/div change that must be ignored (R6, R9, R10).
  task automatic xfer(input logic [7:0] b, input bit dm, input logic [1:0] dv,
                      input logic [7:0] dvd, input logic [7:0] mb, input bit poke);
    int slots = dm ? 4 : 8;
    int p = int'(dvd) + 1;
    logic [1:0] cs_exp = (dv == 2'd2) ? 2'b10 : 2'b01;
    string tag = dm ? "R3" : "R2";
    @(negedge clk);
    start = 1'b1; tx_byte = b; dual = dm; dev = dv; div = dvd;
    for (int s = 0; s < slots; s++) begin
      logic m_exp = dm ? b[7-2*s] : b[7-s];
      logic a_exp = dm ? b[6-2*s] : 1'b1;
      for (int h = 0; h < 2; h++) begin
        for (int k = 0; k < p; k++) begin
          @(negedge clk);
          start = 1'b0; desel = 1'b0;
          if (h == 0 && k == 0) miso = mb[7-s];
          if (poke && s == 2 && h == 0 && k == 0) begin
            start = 1'b1; desel = 1'b1; tx_byte = ~b; dual = ~dm;
            dev = dv ^ 2'd2; div = dvd + 8'd3;
          end
          chk({busy, sclk, mosi} == {1'b1, h[0], m_exp}, tag,
              {busy, sclk, mosi}, {1'b1, h[0], m_exp});
          chk(aux == a_exp, dm ? "R3" : "R4", aux, a_exp);
          if (s == 0 && h == 0 && k == 0)
            chk({cs_sh_n, cs_d2_n} == cs_exp, "R5", {cs_sh_n, cs_d2_n}, cs_exp);
          if (poke && s == 3 && h == 0 && k == 0)
            chk({cs_sh_n, cs_d2_n} == cs_exp, "R6", {cs_sh_n, cs_d2_n}, cs_exp);
        end
      end
    end
    @(negedge clk);
    start = 1'b0; desel = 1'b0;
    if (!dm) rx_model = mb;
    chk({done, busy, sclk} == 3'b100, "R8", {done, busy, sclk}, 3'b100);
    chk(rx == rx_model, "R7", rx, rx_model);
    chk({cs_sh_n, cs_d2_n} == cs_exp, "R5", {cs_sh_n, cs_d2_n}, cs_exp);
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 1'b0);
  endtask

  task automatic t_reset();
    chk({sclk, mosi, cs_sh_n, cs_d2_n, aux, busy, done} == 7'b0011100, "R1",
        {sclk, mosi, cs_sh_n, cs_d2_n, aux, busy, done}, 7'b0011100);
    chk(rx == 8'h00, "R1", rx, 8'h00);
  endtask

  task automatic t_deselect();
    @(negedge clk); desel = 1'b1;
    @(negedge clk); desel = 1'b0;
    chk({cs_sh_n, cs_d2_n} == 2'b11, "R6", {cs_sh_n, cs_d2_n}, 2'b11);
    chk(aux == 1'b1, "R4", aux, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    xfer(8'hA5, 1'b0, 2'd0, 8'd0, 8'h3C, 1'b0);   // R2 R5 R7
    t_deselect();
    xfer(8'h96, 1'b0, 2'd2, 8'd2, 8'hC3, 1'b0);   // R2 R5 R7
    t_deselect();
    xfer(8'h1B, 1'b1, 2'd1, 8'd1, 8'h55, 1'b0);   // R3, rx unchanged (R7)
    t_deselect();
    xfer(8'hE4, 1'b1, 2'd2, 8'd0, 8'hFF, 1'b1);   // R3 R9 R10
    t_deselect();
    xfer(8'h80, 1'b0, 2'd3, 8'd3, 8'h01, 1'b1);   // R9 R10, dev 3 -> shared
    t_deselect();
    summary();
  end
endmodule